// File: doc/BRIEF.md
# Prioritised Interrupt Entry Sequencer

This block sits beside a small 8-bit processor core that has a byte-wide memory port. It watches a vector of per-source request flags and the matching vector of per-source enables. When at least one source is both flagged and enabled, the global mask input is clear, and the core signals that an instruction has just completed, the block takes over the memory port. It then runs a fixed entry sequence.

The sequence has three parts. First, the processor context (program counter, index register, accumulator and condition codes) is written to the stack one byte per cycle while the stack pointer walks downward. Next, the block pulses a request to set the global mask. Finally, it reads a two-byte handler address from the vector slot of the winning source and hands that address back as the new program counter. The source with the highest index wins arbitration. It is chosen once, at acceptance, and held for the whole sequence.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset, `busy_o`, `mem_wr_o`, `mem_rd_o`, `set_mask_o` and `done_o` are 0 and `new_pc_o` is 0.
- R2: A source counts as pending only when both its `flag_i` bit and its `en_i` bit are 1. With no pending source, an instruction-end strobe starts nothing.
- R3: While `gmask_i` is 1, no sequence starts, even with pending sources and an instruction-end strobe.
- R4: A sequence starts only on a cycle with `insn_end_i` high. The first stack write appears in the following cycle.
- R5: The five stacked bytes are, in order: PC[7:0], PC[15:8], X, A, CCR. All values are the ones present on the inputs in the accepting cycle.
- R6: The five writes occupy five consecutive cycles. They go to addresses SP, SP-1, SP-2, SP-3 and SP-4, where SP is `sp_i` sampled at acceptance.
- R7: `set_mask_o` is high for exactly one cycle. That cycle immediately follows the last stack write and is the first vector read cycle.
- R8: The serviced source is the pending source with the highest index n. Its vector base is VEC_TOP - 2n. The high byte is read from the base address in the first read cycle and the low byte from base+1 in the next cycle. `rdata_i` is taken in the same cycle as `mem_rd_o`.
- R9: Changes to `flag_i` or `en_i` after acceptance do not change the vector address that is read.
- R10: `done_o` pulses for one cycle, in the cycle after the low vector read. From that cycle on, `new_pc_o` equals {high byte, low byte} and keeps that value until the next `done_o`.
- R11: `mem_wr_o` and `mem_rd_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_i | input | NSRC | Per-source request flags |
| en_i | input | NSRC | Per-source local enables |
| gmask_i | input | 1 | Global interrupt mask (1 blocks entry) |
| insn_end_i | input | 1 | Instruction-boundary strobe |
| pc_i | input | 16 | Current program counter |
| x_i | input | 8 | Index register |
| a_i | input | 8 | Accumulator |
| ccr_i | input | 8 | Condition code register |
| sp_i | input | 16 | Current stack pointer |
| rdata_i | input | 8 | Memory read data (same-cycle) |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| addr_o | output | 16 | Memory address |
| wdata_o | output | 8 | Memory write data |
| set_mask_o | output | 1 | Pulse: set the global mask |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Pulse: handler address ready |
| new_pc_o | output | 16 | Handler address for the program counter |

## Verification
The assertions assume that `rdata_i` is combinational from `addr_o` within one cycle. They also assume the core does not raise a new instruction-end strobe while `busy_o` is high. The bench meets both conditions: a bench-side memory function derives read data from the address, and the boundary strobe is driven for one cycle only, from an idle state. Flags and enables are deliberately set to all ones during each sequence, so any re-arbitration would show up in the vector address.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef logic [15:0] addr_t;
    typedef logic [7:0]  byte_t;

    localparam int CTX_BYTES = 5;
    localparam int STEP_W    = $clog2(CTX_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_VHI  = 2'd2,
        ST_VLO  = 2'd3
    } seq_state_t;

    typedef struct packed {
        addr_t pc;
        byte_t x;
        byte_t a;
        byte_t ccr;
    } cpu_ctx_t;

    // Vector slot base for a source: top address minus two bytes per index.
    function automatic addr_t slot_base(input addr_t top, input addr_t idx);
        return top - (idx << 1);
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NSRC = 8,
    localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] pend_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (pend_i[i]) begin
                any_o = 1'b1;
                idx_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ctx_mux.sv
module irq_ctx_mux
    import irq_entry_pkg::*;
(
    input  cpu_ctx_t          ctx_i,
    input  logic [STEP_W-1:0] step_i,
    output byte_t             byte_o
);
    always_comb begin
        case (step_i)
            STEP_W'(0): byte_o = ctx_i.pc[7:0];
            STEP_W'(1): byte_o = ctx_i.pc[15:8];
            STEP_W'(2): byte_o = ctx_i.x;
            STEP_W'(3): byte_o = ctx_i.a;
            STEP_W'(4): byte_o = ctx_i.ccr;
            default:    byte_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int    NSRC    = 8,
    parameter addr_t VEC_TOP = 16'hFFFE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            gmask_i,
    input  logic            insn_end_i,
    input  logic [15:0]     pc_i,
    input  logic [7:0]      x_i,
    input  logic [7:0]      a_i,
    input  logic [7:0]      ccr_i,
    input  logic [15:0]     sp_i,
    input  logic [7:0]      rdata_i,
    output logic            mem_wr_o,
    output logic            mem_rd_o,
    output logic [15:0]     addr_o,
    output logic [7:0]      wdata_o,
    output logic            set_mask_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [15:0]     new_pc_o
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CTX_BYTES - 1);

    seq_state_t        st_q;
    logic [STEP_W-1:0] step_q;
    cpu_ctx_t          ctx_q;
    addr_t             sp_q;
    logic [IW-1:0]     src_q;
    byte_t             vhi_q;
    addr_t             new_pc_q;
    logic              done_q;

    logic [NSRC-1:0] pend;
    logic            any_pend;
    logic [IW-1:0]   win_idx;
    logic            accept;
    byte_t           push_byte;
    addr_t           base;

    assign pend = flag_i & en_i;

    irq_pick #(.NSRC(NSRC)) u_pick (
        .pend_i (pend),
        .any_o  (any_pend),
        .idx_o  (win_idx)
    );

    irq_ctx_mux u_mux (
        .ctx_i  (ctx_q),
        .step_i (step_q),
        .byte_o (push_byte)
    );

    assign accept = (st_q == ST_IDLE) && insn_end_i && !gmask_i && any_pend;
    assign base   = slot_base(VEC_TOP, addr_t'(src_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            step_q   <= '0;
            ctx_q    <= '0;
            sp_q     <= '0;
            src_q    <= '0;
            vhi_q    <= '0;
            new_pc_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q   <= ST_PUSH;
                        step_q <= '0;
                        src_q  <= win_idx;
                        sp_q   <= sp_i;
                        ctx_q  <= '{pc: pc_i, x: x_i, a: a_i, ccr: ccr_i};
                    end
                end
                ST_PUSH: begin
                    sp_q <= sp_q - 16'd1;
                    if (step_q == LAST_STEP) begin
                        st_q <= ST_VHI;
                    end else begin
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                ST_VHI: begin
                    vhi_q <= rdata_i;
                    st_q  <= ST_VLO;
                end
                ST_VLO: begin
                    new_pc_q <= {vhi_q, rdata_i};
                    done_q   <= 1'b1;
                    st_q     <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_wr_o   = 1'b0;
        mem_rd_o   = 1'b0;
        set_mask_o = 1'b0;
        addr_o     = '0;
        wdata_o    = '0;
        case (st_q)
            ST_PUSH: begin
                mem_wr_o = 1'b1;
                addr_o   = sp_q;
                wdata_o  = push_byte;
            end
            ST_VHI: begin
                mem_rd_o   = 1'b1;
                set_mask_o = 1'b1;
                addr_o     = base;
            end
            ST_VLO: begin
                mem_rd_o = 1'b1;
                addr_o   = base + 16'd1;
            end
            default: ;
        endcase
    end

    assign busy_o   = (st_q != ST_IDLE);
    assign done_o   = done_q;
    assign new_pc_o = new_pc_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        gmask_i,
    input logic        insn_end_i,
    input logic        mem_wr_o,
    input logic        mem_rd_o,
    input logic [15:0] addr_o,
    input logic        set_mask_o,
    input logic        busy_o,
    input logic        done_o
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_wr_o && mem_rd_o)); // R11

    AST_MASKED_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && gmask_i) |=> !busy_o); // R3

    AST_NO_BOUNDARY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !insn_end_i) |=> !busy_o); // R4

    AST_PUSH_ADDR_DESC: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o && $past(mem_wr_o)) |-> (addr_o == 16'($past(addr_o) - 16'd1))); // R6

    AST_MASK_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
        set_mask_o |-> ($past(mem_wr_o) && mem_rd_o)); // R7

    AST_VEC_LO_NEXT: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && $past(mem_rd_o)) |-> (addr_o == 16'($past(addr_o) + 16'd1))); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R10
endmodule

bind irq_entry_seq irq_entry_seq_chk u_chk (.*);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
    localparam int          NSRC    = 8;
    localparam logic [15:0] VEC_TOP = 16'hFFFE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSRC-1:0] flag_i = '0, en_i = '0;
    logic gmask_i = 1'b0, insn_end_i = 1'b0;
    logic [15:0] pc_i = '0, sp_i = '0;
    logic [7:0]  x_i = '0, a_i = '0, ccr_i = '0;
    logic [7:0]  rdata_i;
    logic mem_wr_o, mem_rd_o, set_mask_o, busy_o, done_o;
    logic [15:0] addr_o, new_pc_o;
    logic [7:0]  wdata_o;

    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    // Bench memory: read data is a fixed function of the address.
    assign rdata_i = addr_o[7:0] ^ 8'hA5;

    irq_entry_seq #(.NSRC(NSRC), .VEC_TOP(VEC_TOP)) dut_i (
        .clk, .rst, .flag_i, .en_i, .gmask_i, .insn_end_i, .pc_i, .x_i, .a_i,
        .ccr_i, .sp_i, .rdata_i, .mem_wr_o, .mem_rd_o, .addr_o, .wdata_o,
        .set_mask_o, .busy_o, .done_o, .new_pc_o
    );

    typedef struct packed {
        logic [7:0]  flag;
        logic [7:0]  en;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  x;
        logic [7:0]  a;
        logic [7:0]  ccr;
        logic [2:0]  idx;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VT [NV] = '{
        '{flag: 8'h01, en: 8'h01, pc: 16'h1234, sp: 16'h00FF, x: 8'h11, a: 8'h22, ccr: 8'h60, idx: 3'd0},
        '{flag: 8'hFF, en: 8'h0F, pc: 16'hBEEF, sp: 16'h0480, x: 8'h5A, a: 8'hC3, ccr: 8'h68, idx: 3'd3},
        '{flag: 8'h8A, en: 8'hFF, pc: 16'h8001, sp: 16'h0103, x: 8'h00, a: 8'hFF, ccr: 8'h61, idx: 3'd7},
        '{flag: 8'h3C, en: 8'h24, pc: 16'h0F0F, sp: 16'h0002, x: 8'h7E, a: 8'h81, ccr: 8'h6F, idx: 3'd5},
        '{flag: 8'h40, en: 8'hC0, pc: 16'hA55A, sp: 16'h07F0, x: 8'h33, a: 8'h44, ccr: 8'h62, idx: 3'd6}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        logic [15:0] base, exp_pc;
        logic [7:0]  exp_b;
        base   = VEC_TOP - 16'(2 * int'(v.idx));
        exp_pc = {base[7:0] ^ 8'hA5, 8'(base + 16'd1) ^ 8'hA5};
        @(negedge clk);
        flag_i = v.flag; en_i = v.en; pc_i = v.pc; sp_i = v.sp;
        x_i = v.x; a_i = v.a; ccr_i = v.ccr; gmask_i = 1'b0; insn_end_i = 1'b1;
        @(negedge clk);
        insn_end_i = 1'b0;
        flag_i = '1; en_i = '1;                       // R9: late requests must not re-arbitrate
        pc_i = ~v.pc; x_i = ~v.x; a_i = ~v.a; ccr_i = ~v.ccr; sp_i = ~v.sp;
        for (int k = 0; k < 5; k++) begin
            case (k)
                0: exp_b = v.pc[7:0];
                1: exp_b = v.pc[15:8];
                2: exp_b = v.x;
                3: exp_b = v.a;
                default: exp_b = v.ccr;
            endcase
            chk(mem_wr_o && !mem_rd_o, "R6 write strobe", {30'd0, mem_wr_o, mem_rd_o}, 32'h2);
            chk(addr_o == v.sp - 16'(k), "R6 push address", addr_o, v.sp - 16'(k));
            chk(wdata_o == exp_b, "R5 push byte", wdata_o, exp_b);
            chk(!set_mask_o, "R7 no mask during push", set_mask_o, 0);
            @(negedge clk);
        end
        chk(mem_rd_o && !mem_wr_o, "R8 high read strobe", {30'd0, mem_wr_o, mem_rd_o}, 32'h1);
        chk(set_mask_o, "R7 mask pulse", set_mask_o, 1);
        chk(addr_o == base, "R8 R9 high vector address", addr_o, base);
        @(negedge clk);
        chk(mem_rd_o, "R8 low read strobe", mem_rd_o, 1);
        chk(!set_mask_o, "R7 mask single cycle", set_mask_o, 0);
        chk(addr_o == base + 16'd1, "R8 low vector address", addr_o, base + 16'd1);
        @(negedge clk);
        chk(done_o, "R10 done pulse", done_o, 1);
        chk(new_pc_o == exp_pc, "R10 new pc", new_pc_o, exp_pc);
        flag_i = '0; en_i = '0;
        @(negedge clk);
        chk(!done_o, "R10 done drops", done_o, 0);
        chk(new_pc_o == exp_pc, "R10 new pc held", new_pc_o, exp_pc);
        chk(!busy_o, "R10 back to idle", busy_o, 0);
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !mem_wr_o && !mem_rd_o, "R1 idle strobes", {29'd0, busy_o, mem_wr_o, mem_rd_o}, 0);
        chk(!set_mask_o && !done_o, "R1 no pulses", {30'd0, set_mask_o, done_o}, 0);
        chk(new_pc_o == 16'h0, "R1 new pc reset", new_pc_o, 0);

        // Table walk: R5 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) run_vec(VT[i]);

        // R3: mask set blocks entry
        flag_i = 8'h10; en_i = 8'h10; gmask_i = 1'b1; insn_end_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!busy_o && !mem_wr_o, "R3 masked no entry", {30'd0, busy_o, mem_wr_o}, 0);
        end

        // R4: no boundary strobe, no entry
        gmask_i = 1'b0; insn_end_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!busy_o && !mem_wr_o, "R4 no boundary no entry", {30'd0, busy_o, mem_wr_o}, 0);
        end
        insn_end_i = 1'b1; sp_i = 16'h0200;
        @(negedge clk);
        insn_end_i = 1'b0;
        chk(busy_o && mem_wr_o && addr_o == 16'h0200, "R4 first write after boundary",
            {15'd0, busy_o, addr_o}, 32'h1_0200);
        flag_i = '0; en_i = '0;
        repeat (9) @(negedge clk);
        chk(!busy_o, "R4 sequence finished", busy_o, 0);

        // R2: flags and enables on disjoint sources
        flag_i = 8'h0F; en_i = 8'hF0; insn_end_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!busy_o && !mem_wr_o, "R2 nothing pending", {30'd0, busy_o, mem_wr_o}, 0);
        end
        insn_end_i = 1'b0;

        // R11 spot check: idle state keeps both strobes low
        chk(!(mem_wr_o && mem_rd_o), "R11 strobes exclusive", {30'd0, mem_wr_o, mem_rd_o}, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule